// File: doc/BRIEF.md
# Triple-Loop Voltage and Frequency Governor

This block sets the supply voltage and the clock frequency of one chip. It sends a voltage code in millivolts to an off-chip regulator and a frequency code, counted in 10 MHz steps, to the on-chip clock generator. A strobe, `tick`, marks each control interval. At each tick three loops compete for the two settings.

The thermal loop has the highest priority. It steps the voltage down while the die is hot. Once it has engaged, it lets go only after the temperature falls below a second, lower limit. The board power loop comes next. It follows raise and lower commands from a board-level budget manager, and it acts only after a command has been held for a set number of consecutive ticks. The frequency loop has the lowest priority. It searches for the fastest clock that still passes an at-speed self test run in the pipeline. A failing result steps the clock down at once. A step up needs a programmable count of passes in a row.

At most one setting changes in each interval. Speed results arrive on a valid/ready stream and are held until the frequency loop gets an interval in which to use them.

Top module: `vf_governor`

## Requirements
- R1: After reset the voltage code is 630 mV, the frequency code is 50, `speed_ready` is high, `hot_flag` is low, and `last_act` and `temp_seen` are 0.
- R2: The voltage code stays within 550 to 800 mV and moves by at most 1 mV per change. The frequency code stays within 20 to 100 and moves by at most one step per change. A loop that asks to go past a limit is refused, and the setting holds.
- R3: The voltage and frequency codes change only on a clock edge where `tick` is high. At most one of the two changes on any one tick.
- R4: When the frequency loop processes a held failing result (`speed_pass`=0), it lowers the frequency code by one step in that same interval and clears the pass streak.
- R5: When the frequency loop processes a held passing result, it raises the frequency code by one step if that result completes `pass_need` passes in a row, and it then clears the streak. A `pass_need` of 0 counts as 1. Ticks that carry no result neither advance the streak nor reset it.
- R6: A tick with `temp_c` >= `hot_limit` sets `hot_flag`. On every tick where the flag is set and the voltage is above its floor, the voltage drops by 1 mV. While the flag is set, raise commands from the power loop are not applied.
- R7: Once set, `hot_flag` clears only on a tick with `temp_c` < `cool_limit`. Temperatures between the two limits leave the flag set.
- R8: A command (`budget_up` alone = raise, `budget_down` alone = lower) moves the voltage by 1 mV on the tick that completes HOLD_TICKS (3) consecutive ticks of that same command. After it acts, the count starts again. A tick with no command, with both inputs high, or with the opposite command restarts the count. A ripe command that is blocked keeps its ripe state.
- R9: The loops rank thermal, then power, then frequency. A lower-ranked loop does not act in an interval that a higher-ranked loop uses. A speed result that is held back this way stays held until the frequency loop gets an interval.
- R10: `speed_ready` is high exactly when no result is held. A result transfers on a clock edge where `speed_valid` and `speed_ready` are both high. A result offered while one is held is not taken.
- R11: Each tick loads `temp_seen` with `temp_c`. It also loads `last_act` with the code of the loop that changed a setting (0 none, 1 thermal, 2 power, 3 frequency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe that starts a control interval |
| speed_valid | input | 1 | A speed result is offered |
| speed_ready | output | 1 | The block can take a speed result |
| speed_pass | input | 1 | Speed result: 1 pass, 0 fail |
| temp_c | input | 8 | Die temperature in degrees C |
| hot_limit | input | 8 | Temperature that engages the thermal loop |
| cool_limit | input | 8 | Release threshold; the flag clears below this value |
| pass_need | input | 4 | Consecutive passes needed for a frequency step up |
| budget_up | input | 1 | Budget manager asks for more voltage |
| budget_down | input | 1 | Budget manager asks for less voltage |
| volt_mv | output | 10 | Voltage code in mV |
| freq_step | output | 7 | Frequency code in 10 MHz units |
| temp_seen | output | 8 | Temperature captured on the last tick |
| hot_flag | output | 1 | Thermal loop engaged |
| last_act | output | 2 | Loop that acted on the last tick |

## Verification
The assertions assume that `tick` is a single-cycle strobe, that `cool_limit` is not above `hot_limit`, and that `temp_c`, the limits and `pass_need` hold steady around the edge where a tick samples them. The bench changes these inputs only on falling clock edges, and only between ticks. It raises `speed_valid` for one cycle at a time, so no result is offered while one is held, except in the one test that exercises back-pressure. There a failing result is offered for exactly one cycle while `speed_ready` is low, to show that it is dropped. Budget commands are held across whole intervals, so the hold counts match the requirement exactly.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_THERM = 2'd1,
    ACT_POWER = 2'd2,
    ACT_FREQ  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RAISE = 2'd1,
    CMD_LOWER = 2'd2
  } cmd_e;
endpackage

// File: rtl/vfg_thermal.sv
module vfg_thermal #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] hot_lim,
  input  logic [TEMP_W-1:0] cool_lim,
  output logic              hot_now,
  output logic              hot_q
);
  // Set at the hot limit, released only below the cool limit.
  always_comb begin
    hot_now = (temp >= hot_lim) | (hot_q & (temp >= cool_lim));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hot_q <= 1'b0;
    else if (tick) hot_q <= hot_now;
  end

  assert_hot_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_q) |-> $past(temp >= hot_lim));
  assert_hot_release_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hot_q) |-> $past(temp < cool_lim));
  assert_hot_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hot_q));
endmodule

// File: rtl/vfg_budget.sv
module vfg_budget import vfg_pkg::*; #(
  parameter int HOLD_TICKS = 3,
  localparam int CW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raise,
  input  logic lower,
  input  logic granted,
  output logic ripe_raise,
  output logic ripe_lower
);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_TICKS);

  cmd_e          cmd, prev_q;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (raise && !lower)      cmd = CMD_RAISE;
    else if (lower && !raise) cmd = CMD_LOWER;
    else                      cmd = CMD_NONE;

    if (cmd == CMD_NONE)     cnt_n = '0;
    else if (cmd != prev_q)  cnt_n = CW'(1);
    else if (cnt_q >= HOLD_C) cnt_n = HOLD_C;
    else                     cnt_n = cnt_q + CW'(1);

    ripe_raise = (cmd == CMD_RAISE) && (cnt_n == HOLD_C);
    ripe_lower = (cmd == CMD_LOWER) && (cnt_n == HOLD_C);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= CMD_NONE;
      cnt_q  <= '0;
    end else if (tick) begin
      prev_q <= cmd;
      cnt_q  <= granted ? '0 : cnt_n;
    end
  end

  assert_budget_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ripe_raise, ripe_lower}));

  generate
    if (HOLD_TICKS > 1) begin : g_hist
      assert_raise_needs_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ripe_raise |-> prev_q == CMD_RAISE);
      assert_lower_needs_history_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ripe_lower |-> prev_q == CMD_LOWER);
    end
  endgenerate
endmodule

// File: rtl/vfg_speed.sv
module vfg_speed #(
  parameter int NEED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_pass,
  input  logic [NEED_W-1:0] pass_need,
  input  logic              tick,
  input  logic              grant,
  output logic              want_up,
  output logic              want_down
);
  logic              held_q, pass_q;
  logic [NEED_W-1:0] streak_q;
  logic [NEED_W:0]   need, streak_n;
  logic              consume;

  always_comb begin
    need     = (pass_need == '0) ? (NEED_W+1)'(1) : {1'b0, pass_need};
    streak_n = {1'b0, streak_q} + (NEED_W+1)'(1);
    in_ready = !held_q;
    want_down = held_q && !pass_q;
    want_up   = held_q && pass_q && (streak_n >= need);
    consume   = tick && grant && held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      pass_q   <= 1'b0;
      streak_q <= '0;
    end else if (consume) begin
      held_q <= 1'b0;
      if (!pass_q || want_up) streak_q <= '0;
      else                    streak_q <= streak_n[NEED_W-1:0];
    end else if (in_valid && !held_q) begin
      held_q <= 1'b1;
      pass_q <= in_pass;
    end
  end

  assert_result_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  assert_result_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    held_q && !(tick && grant) |=> held_q && $stable(pass_q));
endmodule

// File: rtl/vf_governor.sv
module vf_governor import vfg_pkg::*; #(
  parameter int VMIN_MV    = 550,
  parameter int VMAX_MV    = 800,
  parameter int VNOM_MV    = 630,
  parameter int FMIN_STEP  = 20,
  parameter int FMAX_STEP  = 100,
  parameter int FINIT_STEP = 50,
  parameter int TEMP_W     = 8,
  parameter int NEED_W     = 4,
  parameter int HOLD_TICKS = 3,
  localparam int VW = $clog2(VMAX_MV + 1),
  localparam int FW = $clog2(FMAX_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              speed_valid,
  output logic              speed_ready,
  input  logic              speed_pass,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic [TEMP_W-1:0] hot_limit,
  input  logic [TEMP_W-1:0] cool_limit,
  input  logic [NEED_W-1:0] pass_need,
  input  logic              budget_up,
  input  logic              budget_down,
  output logic [VW-1:0]     volt_mv,
  output logic [FW-1:0]     freq_step,
  output logic [TEMP_W-1:0] temp_seen,
  output logic              hot_flag,
  output logic [1:0]        last_act
);
  localparam logic [VW-1:0] VMIN_C = VW'(VMIN_MV);
  localparam logic [VW-1:0] VMAX_C = VW'(VMAX_MV);
  localparam logic [VW-1:0] VNOM_C = VW'(VNOM_MV);
  localparam logic [FW-1:0] FMIN_C = FW'(FMIN_STEP);
  localparam logic [FW-1:0] FMAX_C = FW'(FMAX_STEP);
  localparam logic [FW-1:0] FINI_C = FW'(FINIT_STEP);

  logic [VW-1:0] volt_q;
  logic [FW-1:0] freq_q;
  act_e          act_q;
  logic [TEMP_W-1:0] temp_q;

  logic hot_now, hot_q;
  logic ripe_raise, ripe_lower;
  logic want_up, want_down;
  logic therm_go, pwr_up, pwr_dn, pwr_go, frq_grant, frq_up, frq_dn, frq_go;

  vfg_thermal #(.TEMP_W(TEMP_W)) u_thermal (
    .clk(clk), .rst_n(rst_n), .tick(tick), .temp(temp_c),
    .hot_lim(hot_limit), .cool_lim(cool_limit),
    .hot_now(hot_now), .hot_q(hot_q)
  );

  vfg_budget #(.HOLD_TICKS(HOLD_TICKS)) u_budget (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .raise(budget_up), .lower(budget_down), .granted(pwr_go),
    .ripe_raise(ripe_raise), .ripe_lower(ripe_lower)
  );

  vfg_speed #(.NEED_W(NEED_W)) u_speed (
    .clk(clk), .rst_n(rst_n),
    .in_valid(speed_valid), .in_ready(speed_ready), .in_pass(speed_pass),
    .pass_need(pass_need), .tick(tick), .grant(frq_grant),
    .want_up(want_up), .want_down(want_down)
  );

  // Fixed-priority arbitration: thermal, then power, then frequency.
  always_comb begin
    therm_go  = tick && hot_now && (volt_q > VMIN_C);
    pwr_up    = ripe_raise && !hot_now && (volt_q < VMAX_C);
    pwr_dn    = ripe_lower && (volt_q > VMIN_C);
    pwr_go    = tick && !therm_go && (pwr_up || pwr_dn);
    frq_grant = !therm_go && !pwr_go;
    frq_up    = frq_grant && want_up && (freq_q < FMAX_C);
    frq_dn    = frq_grant && want_down && (freq_q > FMIN_C);
    frq_go    = tick && (frq_up || frq_dn);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      volt_q <= VNOM_C;
      freq_q <= FINI_C;
      act_q  <= ACT_IDLE;
      temp_q <= '0;
    end else if (tick) begin
      temp_q <= temp_c;
      if (therm_go) begin
        volt_q <= volt_q - VW'(1);
        act_q  <= ACT_THERM;
      end else if (pwr_go) begin
        volt_q <= pwr_up ? volt_q + VW'(1) : volt_q - VW'(1);
        act_q  <= ACT_POWER;
      end else if (frq_go) begin
        freq_q <= frq_up ? freq_q + FW'(1) : freq_q - FW'(1);
        act_q  <= ACT_FREQ;
      end else begin
        act_q  <= ACT_IDLE;
      end
    end
  end

  assign volt_mv   = volt_q;
  assign freq_step = freq_q;
  assign temp_seen = temp_q;
  assign hot_flag  = hot_q;
  assign last_act  = act_q;

  assert_volt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    volt_q >= VMIN_C && volt_q <= VMAX_C);
  assert_freq_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    freq_q >= FMIN_C && freq_q <= FMAX_C);
  assert_volt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (volt_q == $past(volt_q)) || (volt_q == $past(volt_q) + VW'(1))
             || (volt_q == $past(volt_q) - VW'(1)));
  assert_freq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (freq_q == $past(freq_q)) || (freq_q == $past(freq_q) + FW'(1))
             || (freq_q == $past(freq_q) - FW'(1)));
  assert_quiet_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(volt_q) && $stable(freq_q));
  assert_single_actuator_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(volt_q) || $stable(freq_q));
  assert_no_raise_when_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hot_now |=> volt_q <= $past(volt_q));
  assert_thermal_blocks_freq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    therm_go |=> $stable(freq_q));
endmodule

// File: tb/vf_governor_test.sv
module vf_governor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       speed_valid = 1'b0;
  logic       speed_pass = 1'b0;
  logic       speed_ready;
  logic [7:0] temp_c = 8'd60;
  logic [7:0] hot_limit = 8'd125;
  logic [7:0] cool_limit = 8'd115;
  logic [3:0] pass_need = 4'd3;
  logic       budget_up = 1'b0;
  logic       budget_down = 1'b0;
  logic [9:0] volt_mv;
  logic [6:0] freq_step;
  logic [7:0] temp_seen;
  logic       hot_flag;
  logic [1:0] last_act;

  int checks = 0;
  int errors = 0;
  bit ended = 0;
  int exp_v = 630;
  int exp_f = 50;

  always #4 clk = ~clk;

  vf_governor uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .speed_valid(speed_valid), .speed_ready(speed_ready), .speed_pass(speed_pass),
    .temp_c(temp_c), .hot_limit(hot_limit), .cool_limit(cool_limit),
    .pass_need(pass_need), .budget_up(budget_up), .budget_down(budget_down),
    .volt_mv(volt_mv), .freq_step(freq_step), .temp_seen(temp_seen),
    .hot_flag(hot_flag), .last_act(last_act)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_vf(input string req, input int act_code);
    chk(req, "volt_mv", int'(volt_mv), exp_v);
    chk(req, "freq_step", int'(freq_step), exp_f);
    chk(req, "last_act", int'(last_act), act_code);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic send(input bit p);
    @(negedge clk); speed_valid = 1'b1; speed_pass = p;
    @(negedge clk); speed_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic test_reset();
    chk("R1", "volt_mv", int'(volt_mv), 630);
    chk("R1", "freq_step", int'(freq_step), 50);
    chk("R1", "speed_ready", int'(speed_ready), 1);
    chk("R1", "hot_flag", int'(hot_flag), 0);
    chk("R1", "last_act", int'(last_act), 0);
    chk("R1", "temp_seen", int'(temp_seen), 0);
  endtask

  task automatic test_freq_search();
    pass_need = 4'd3;
    do_tick();
    chk_vf("R5", 0);
    send(1'b1);
    chk("R10", "ready after capture", int'(speed_ready), 0);
    send(1'b0); // offered while held: must be dropped
    do_tick();
    chk_vf("R10", 0);
    chk("R10", "ready after use", int'(speed_ready), 1);
    do_tick();
    send(1'b1); do_tick();
    chk_vf("R5", 0);
    send(1'b1); do_tick();
    exp_f = 51; chk_vf("R5", 3);
    send(1'b0); do_tick();
    exp_f = 50; chk_vf("R4", 3);
    send(1'b1); do_tick();
    send(1'b1); do_tick();
    chk_vf("R4", 0);
    send(1'b1); do_tick();
    exp_f = 51; chk_vf("R5", 3);
  endtask

  task automatic test_freq_limits();
    pass_need = 4'd0;
    for (int i = 0; i < 49; i++) begin send(1'b1); do_tick(); end
    exp_f = 100; chk_vf("R5", 3);
    send(1'b1); do_tick();
    chk_vf("R2", 0);
    send(1'b0); do_tick();
    exp_f = 99; chk_vf("R4", 3);
    pass_need = 4'd1;
    send(1'b1); do_tick();
    exp_f = 100; chk_vf("R5", 3);
    for (int i = 0; i < 80; i++) begin send(1'b0); do_tick(); end
    exp_f = 20; chk_vf("R2", 3);
    send(1'b0); do_tick();
    chk_vf("R2", 0);
  endtask

  task automatic test_power();
    budget_up = 1'b1;
    do_tick(); do_tick();
    chk_vf("R8", 0);
    do_tick();
    exp_v = 631; chk_vf("R8", 2);
    do_tick(); do_tick();
    chk_vf("R8", 0);
    do_tick();
    exp_v = 632; chk_vf("R8", 2);
    do_tick(); do_tick();
    budget_up = 1'b0; do_tick();
    budget_up = 1'b1; do_tick(); do_tick();
    chk_vf("R8", 0);
    budget_up = 1'b1; budget_down = 1'b1;
    do_tick(); do_tick(); do_tick();
    chk_vf("R8", 0);
    budget_up = 1'b0;
    do_tick(); do_tick(); do_tick();
    exp_v = 631; chk_vf("R8", 2);
    budget_down = 1'b0; budget_up = 1'b1;
    do_tick(); do_tick();
    budget_up = 1'b0; budget_down = 1'b1;
    do_tick(); do_tick();
    chk_vf("R8", 0);
    do_tick();
    exp_v = 630; chk_vf("R8", 2);
    budget_down = 1'b0; budget_up = 1'b1;
    do_tick(); do_tick();
    send(1'b1);
    do_tick();
    exp_v = 631; chk_vf("R9", 2);
    chk("R9", "result still held", int'(speed_ready), 0);
    budget_up = 1'b0;
    do_tick();
    exp_f = 21; chk_vf("R9", 3);
    chk("R10", "ready after use", int'(speed_ready), 1);
  endtask

  task automatic test_thermal();
    temp_c = 8'd124; do_tick();
    chk("R6", "hot_flag below limit", int'(hot_flag), 0);
    chk("R11", "temp_seen", int'(temp_seen), 124);
    chk_vf("R6", 0);
    temp_c = 8'd125; do_tick();
    chk("R6", "hot_flag at limit", int'(hot_flag), 1);
    exp_v = 630; chk_vf("R6", 1);
    budget_up = 1'b1; temp_c = 8'd120;
    do_tick(); do_tick(); do_tick();
    chk("R7", "hot_flag between limits", int'(hot_flag), 1);
    exp_v = 627; chk_vf("R6", 1);
    temp_c = 8'd115; do_tick();
    chk("R7", "hot_flag at cool limit", int'(hot_flag), 1);
    exp_v = 626; chk_vf("R7", 1);
    temp_c = 8'd114; do_tick();
    chk("R7", "hot_flag released", int'(hot_flag), 0);
    chk("R11", "temp_seen", int'(temp_seen), 114);
    exp_v = 627; chk_vf("R8", 2);
    budget_up = 1'b0; budget_down = 1'b1; temp_c = 8'd60;
    do_tick(); do_tick();
    chk_vf("R8", 0);
    temp_c = 8'd130; do_tick();
    exp_v = 626; chk_vf("R9", 1);
    temp_c = 8'd60; do_tick();
    exp_v = 625; chk_vf("R9", 2);
    budget_down = 1'b0;
  endtask

  task automatic test_volt_limits();
    budget_down = 1'b1;
    for (int i = 0; i < 225; i++) do_tick();
    exp_v = 550; chk_vf("R2", 2);
    do_tick(); do_tick(); do_tick();
    chk_vf("R2", 0);
    temp_c = 8'd130; do_tick();
    chk("R6", "hot_flag at floor", int'(hot_flag), 1);
    chk_vf("R6", 0);
    temp_c = 8'd60; budget_down = 1'b0; do_tick();
    chk("R7", "hot_flag released", int'(hot_flag), 0);
    budget_up = 1'b1;
    for (int i = 0; i < 750; i++) do_tick();
    exp_v = 800; chk_vf("R2", 2);
    do_tick(); do_tick(); do_tick();
    chk_vf("R2", 0);
    budget_up = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_freq_search();
    test_freq_limits();
    test_power();
    test_thermal();
    test_volt_limits();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule